// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A caller presents the virtual address together with the table base it should use. The walker then issues one 32-bit read per level over a simple request/response memory port and decodes what comes back. It returns a physical address up to 40 bits wide, the execute-never bit and a 3-bit memory-type index, or it returns a translation fault together with the level that caused it.

The first-level table has 4096 word entries indexed by address bits 31..20. An entry there can be a 1MB section, a 16MB supersection that widens the output to 40 bits, or a pointer to a 1KB second-level table of 256 entries, each mapping a 4KB page. Only one walk is in progress at a time. While a walk runs the block holds `busy` high and ignores new requests.

Top module: `tableWalker`

## Requirements
- R1: After reset `busy`, `memReqValid` and `doneValid` are all low.
- R2: A request with `reqValid` high while `busy` is low is accepted at the clock edge. In the next cycle `busy` is high and a single-cycle first-level read is issued at address {reqBase[31:14], reqVa[31:20], 2'b00}.
- R3: `reqValid` has no effect while `busy` is high. The walk in progress keeps its addresses and its result, and no further walk starts once it finishes.
- R4: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk with `doneFault` = 1 and `doneLevel` = 0. In that case `donePa`, `doneXn`, `doneMemType` and `doneKind` are all zero.
- R5: A first-level descriptor with bits [1:0] = 10 and bit 18 = 0 is a 1MB section. It gives `donePa` = {8'h00, d[31:20], va[19:0]}, `doneXn` = d[4], `doneMemType` = {d[12], d[3:2]}, `doneKind` = 0 and `doneLevel` = 0.
- R6: A first-level descriptor with bits [1:0] = 10 and bit 18 = 1 is a 16MB supersection. It gives `donePa` = {d[9:6], d[23:20], d[31:24], va[23:0]} and `doneKind` = 1. Its XN, memory-type and level fields are set as in R5.
- R7: A first-level descriptor with bits [1:0] = 01 points to a second-level table. Exactly one second-level read is then issued at address {d[31:10], va[19:12], 2'b00}.
- R8: A second-level descriptor with bit 1 = 1 is a 4KB page. It gives `donePa` = {8'h00, d[31:12], va[11:0]}, `doneXn` = d[0], `doneMemType` = {d[5], d[3:2]}, `doneKind` = 2 and `doneLevel` = 1.
- R9: A second-level descriptor with bit 1 = 0 ends the walk with `doneFault` = 1 and `doneLevel` = 1. The other result fields are zero.
- R10: `doneValid` pulses for exactly one cycle, the cycle after the final response is sampled. In that same cycle `busy` is already low.
- R11: Each `memReqValid` pulse lasts one cycle. No new read is issued while a response is still awaited, whatever the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVa | input | 32 | Virtual address to translate |
| reqBase | input | 32 | Table base register value |
| busy | output | 1 | Walk in progress; requests ignored |
| memReqValid | output | 1 | Memory read request pulse |
| memReqAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Descriptor read from memory |
| doneValid | output | 1 | Result valid pulse |
| donePa | output | 40 | Translated physical address |
| doneXn | output | 1 | Execute-never bit from the descriptor |
| doneMemType | output | 3 | Memory-type remap index |
| doneKind | output | 2 | 0 section, 1 supersection, 2 page |
| doneLevel | output | 1 | Level where the walk ended (0 first, 1 second) |
| doneFault | output | 1 | Translation fault |

## Verification
The case hardest to reach from the ports is a new request arriving in the middle of a walk, while the walker is waiting on memory, especially during the wait between the first-level pointer and the second-level read. The bench's memory responder holds the data back for a chosen latency of one to three cycles. On selected walks it raises `reqValid` with an unrelated address and base throughout that wait. It then checks that the second-level address, the final result and the idle cycle after completion all belong to the original walk. The sweep covers every descriptor class under several virtual addresses and latencies.

// File: rtl/twPkg.sv
package twPkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 40;
  localparam int DESC_W    = 32;
  localparam int L1_IDX_W  = 12;
  localparam int L2_IDX_W  = 8;
  localparam int PAGE_W    = 12;
  localparam int SEC_W     = VA_W - L1_IDX_W;          // 20 offset bits
  localparam int SUPER_W   = 24;
  localparam int L1_BASE_W = VA_W - L1_IDX_W - 2;      // 18 base bits
  localparam int L2_BASE_W = VA_W - L2_IDX_W - 2;      // 22 base bits
  localparam int EXT_W     = PA_W - VA_W;              // 8 extra PA bits

  typedef enum logic [2:0] {
    DK_FAULT   = 3'd0,
    DK_TABLE   = 3'd1,
    DK_SECTION = 3'd2,
    DK_SUPER   = 3'd3,
    DK_PAGE    = 3'd4
  } descKindT;

  typedef enum logic [1:0] {
    RK_SECTION = 2'd0,
    RK_SUPER   = 2'd1,
    RK_PAGE    = 2'd2
  } resultKindT;

  typedef struct packed {
    logic latchReq;
    logic latchTable;
    logic loadLeaf;
    logic loadFault;
    logic atL2;
  } ctrlStrobeT;
endpackage

// File: rtl/twDatapath.sv
module twDatapath
  import twPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          ctrl,
  input  logic [VA_W-1:0]     reqVa,
  input  logic [VA_W-1:0]     reqBase,
  input  logic [DESC_W-1:0]   memRspData,
  output logic [VA_W-1:0]     memReqAddr,
  output descKindT            rspKind,
  output logic [PA_W-1:0]     donePa,
  output logic                doneXn,
  output logic [2:0]          doneMemType,
  output logic [1:0]          doneKind,
  output logic                doneLevel,
  output logic                doneFault
);
  logic [VA_W-1:0]      vaQ;
  logic [L1_BASE_W-1:0] baseQ;
  logic [L2_BASE_W-1:0] tblQ;

  descKindT             l1Kind, l2Kind;
  logic [PA_W-1:0]      leafPa;
  logic                 leafXn;
  logic [2:0]           leafMt;
  resultKindT           leafKind;

  // descriptor classification per level
  always_comb begin
    unique case (memRspData[1:0])
      2'b01:   l1Kind = DK_TABLE;
      2'b10:   l1Kind = memRspData[18] ? DK_SUPER : DK_SECTION;
      default: l1Kind = DK_FAULT;
    endcase
    l2Kind  = memRspData[1] ? DK_PAGE : DK_FAULT;
    rspKind = ctrl.atL2 ? l2Kind : l1Kind;
  end

  // leaf result formation
  always_comb begin
    leafPa   = '0;
    leafXn   = 1'b0;
    leafMt   = '0;
    leafKind = RK_SECTION;
    if (ctrl.atL2) begin
      leafPa   = {{EXT_W{1'b0}}, memRspData[DESC_W-1:PAGE_W], vaQ[PAGE_W-1:0]};
      leafXn   = memRspData[0];
      leafMt   = {memRspData[5], memRspData[3:2]};
      leafKind = RK_PAGE;
    end else begin
      leafXn = memRspData[4];
      leafMt = {memRspData[12], memRspData[3:2]};
      if (memRspData[18]) begin
        leafPa   = {memRspData[9:6], memRspData[23:20],
                    memRspData[DESC_W-1:SUPER_W], vaQ[SUPER_W-1:0]};
        leafKind = RK_SUPER;
      end else begin
        leafPa   = {{EXT_W{1'b0}}, memRspData[DESC_W-1:SEC_W], vaQ[SEC_W-1:0]};
        leafKind = RK_SECTION;
      end
    end
  end

  // read address: first or second level
  always_comb begin
    if (ctrl.atL2)
      memReqAddr = {tblQ, vaQ[SEC_W-1:PAGE_W], 2'b00};
    else
      memReqAddr = {baseQ, vaQ[VA_W-1:SEC_W], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ         <= '0;
      baseQ       <= '0;
      tblQ        <= '0;
      donePa      <= '0;
      doneXn      <= 1'b0;
      doneMemType <= '0;
      doneKind    <= '0;
      doneLevel   <= 1'b0;
      doneFault   <= 1'b0;
    end else begin
      if (ctrl.latchReq) begin
        vaQ   <= reqVa;
        baseQ <= reqBase[VA_W-1:VA_W-L1_BASE_W];
      end
      if (ctrl.latchTable)
        tblQ <= memRspData[DESC_W-1:DESC_W-L2_BASE_W];
      if (ctrl.loadLeaf) begin
        donePa      <= leafPa;
        doneXn      <= leafXn;
        doneMemType <= leafMt;
        doneKind    <= leafKind;
        doneLevel   <= ctrl.atL2;
        doneFault   <= 1'b0;
      end else if (ctrl.loadFault) begin
        donePa      <= '0;
        doneXn      <= 1'b0;
        doneMemType <= '0;
        doneKind    <= RK_SECTION;
        doneLevel   <= ctrl.atL2;
        doneFault   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twControl.sv
module twControl
  import twPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRspValid,
  input  descKindT   rspKind,
  output ctrlStrobeT ctrl,
  output logic       busy,
  output logic       memReqValid,
  output logic       doneValid
);
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_L1_ISSUE = 3'd1,
    ST_L1_WAIT  = 3'd2,
    ST_L2_ISSUE = 3'd3,
    ST_L2_WAIT  = 3'd4
  } walkStateT;

  walkStateT stateQ, stateD;
  logic      finish;

  always_comb begin
    stateD      = stateQ;
    ctrl        = '0;
    memReqValid = 1'b0;
    finish      = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          stateD        = ST_L1_ISSUE;
        end
      end
      ST_L1_ISSUE: begin
        memReqValid = 1'b1;
        stateD      = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (memRspValid) begin
          if (rspKind == DK_TABLE) begin
            ctrl.latchTable = 1'b1;
            stateD          = ST_L2_ISSUE;
          end else begin
            ctrl.loadFault = (rspKind == DK_FAULT);
            ctrl.loadLeaf  = (rspKind != DK_FAULT);
            finish         = 1'b1;
            stateD         = ST_IDLE;
          end
        end
      end
      ST_L2_ISSUE: begin
        ctrl.atL2   = 1'b1;
        memReqValid = 1'b1;
        stateD      = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        ctrl.atL2 = 1'b1;
        if (memRspValid) begin
          ctrl.loadLeaf  = (rspKind == DK_PAGE);
          ctrl.loadFault = (rspKind != DK_PAGE);
          finish         = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      doneValid <= 1'b0;
    end else begin
      stateQ    <= stateD;
      doneValid <= finish;
    end
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/tableWalker.sv
module tableWalker
  import twPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqVa,
  input  logic [31:0]       reqBase,
  output logic              busy,
  output logic              memReqValid,
  output logic [31:0]       memReqAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              doneValid,
  output logic [39:0]       donePa,
  output logic              doneXn,
  output logic [2:0]        doneMemType,
  output logic [1:0]        doneKind,
  output logic              doneLevel,
  output logic              doneFault
);
  ctrlStrobeT ctrl;
  descKindT   rspKind;

  twControl u_control (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .rspKind     (rspKind),
    .ctrl        (ctrl),
    .busy        (busy),
    .memReqValid (memReqValid),
    .doneValid   (doneValid)
  );

  twDatapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqVa       (reqVa),
    .reqBase     (reqBase),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspKind     (rspKind),
    .donePa      (donePa),
    .doneXn      (doneXn),
    .doneMemType (doneMemType),
    .doneKind    (doneKind),
    .doneLevel   (doneLevel),
    .doneFault   (doneFault)
  );
endmodule

// File: rtl/twChecker.sv
module twChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        memReqValid,
  input logic [31:0] memReqAddr,
  input logic        memRspValid,
  input logic        doneValid,
  input logic [39:0] donePa,
  input logic        doneXn,
  input logic [2:0]  doneMemType,
  input logic [1:0]  doneKind,
  input logic        doneLevel,
  input logic        doneFault
);
  p_accept_issues_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> (busy && memReqValid));

  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneValid && !memRspValid) |=> busy);

  p_fault_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault) |-> (donePa == 40'h0 && !doneXn &&
                                  doneMemType == 3'd0 && doneKind == 2'd0));

  p_section_narrow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneFault && doneKind == 2'd0) |-> (donePa[39:32] == 8'h00 && !doneLevel));

  p_super_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneFault && doneKind == 2'd1) |-> !doneLevel);

  p_page_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneFault && doneKind == 2'd2) |-> (doneLevel && donePa[39:32] == 8'h00));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (!busy && !memReqValid));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_req_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_req_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (busy && memReqAddr[1:0] == 2'b00));
endmodule

bind tableWalker twChecker u_twChecker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .busy        (busy),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .doneValid   (doneValid),
  .donePa      (donePa),
  .doneXn      (doneXn),
  .doneMemType (doneMemType),
  .doneKind    (doneKind),
  .doneLevel   (doneLevel),
  .doneFault   (doneFault)
);

// File: tb/tableWalker_bench.sv
module tableWalker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [31:0] reqBase = '0;
  logic        busy, memReqValid, doneValid, doneXn, doneLevel, doneFault;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [39:0] donePa;
  logic [2:0]  doneMemType;
  logic [1:0]  doneKind;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tableWalker u_tableWalker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqBase(reqBase),
    .busy(busy), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .doneValid(doneValid),
    .donePa(donePa), .doneXn(doneXn), .doneMemType(doneMemType),
    .doneKind(doneKind), .doneLevel(doneLevel), .doneFault(doneFault)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitIdleCycle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!memReqValid && busy, req, {62'd0, memReqValid, busy}, 64'd1);
    end
  endtask

  task automatic doWalk(input logic [31:0] va, input logic [31:0] base,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int lat, input bit poke);
    logic [39:0] ePa;
    logic        eXn, eLvl, eFault, isTable;
    logic [2:0]  eMt;
    logic [1:0]  eKind;
    ePa = '0; eXn = 0; eMt = '0; eKind = '0; eLvl = 0; eFault = 0; isTable = 0;
    case (d1[1:0])
      2'b10: begin
        eXn = d1[4]; eMt = {d1[12], d1[3:2]};
        if (d1[18]) begin ePa = {d1[9:6], d1[23:20], d1[31:24], va[23:0]}; eKind = 2'd1; end
        else        begin ePa = {8'h00, d1[31:20], va[19:0]};             eKind = 2'd0; end
      end
      2'b01: begin
        isTable = 1; eLvl = 1;
        if (d2[1]) begin
          ePa = {8'h00, d2[31:12], va[11:0]}; eXn = d2[0];
          eMt = {d2[5], d2[3:2]}; eKind = 2'd2;
        end else eFault = 1;
      end
      default: eFault = 1;
    endcase

    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqBase = base;
    @(negedge clk);
    check(memReqValid && busy, "R2 issue", {62'd0, memReqValid, busy}, 64'd3);
    check(memReqAddr == {base[31:14], va[31:20], 2'b00}, "R2 l1 addr",
          {32'd0, memReqAddr}, {32'd0, base[31:14], va[31:20], 2'b00});
    reqValid = poke; reqVa = ~va; reqBase = ~base;  // R3 interference
    waitIdleCycle(lat + 1, "R11 wait l1");
    memRspValid = 1'b1; memRspData = d1;
    if (!isTable) reqValid = 1'b0;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = $urandom;
    if (isTable) begin
      check(memReqValid, "R7 l2 issue", {63'd0, memReqValid}, 64'd1);
      check(memReqAddr == {d1[31:10], va[19:12], 2'b00}, "R7 R3 l2 addr",
            {32'd0, memReqAddr}, {32'd0, d1[31:10], va[19:12], 2'b00});
      waitIdleCycle(lat + 1, "R11 wait l2");
      memRspValid = 1'b1; memRspData = d2; reqValid = 1'b0;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = $urandom;
    end
    check(doneValid && !busy, "R10 done", {62'd0, doneValid, busy}, 64'd2);
    check(doneFault == eFault, eFault ? (eLvl ? "R9 fault" : "R4 fault") : "R4 R9 nofault",
          {63'd0, doneFault}, {63'd0, eFault});
    check(doneLevel == eLvl, "R4 R9 level", {63'd0, doneLevel}, {63'd0, eLvl});
    check(donePa == ePa, eKind == 2 ? "R8 pa" : (eKind == 1 ? "R6 pa" : "R5 pa"),
          {24'd0, donePa}, {24'd0, ePa});
    check(doneXn == eXn && doneMemType == eMt && doneKind == eKind, "R5 R6 R8 attrs",
          {56'd0, doneXn, doneMemType, 2'b00, doneKind}, {56'd0, eXn, eMt, 2'b00, eKind});
    @(negedge clk);
    check(!doneValid && !busy && !memReqValid, "R10 R3 quiet after",
          {61'd0, doneValid, busy, memReqValid}, 64'd0);
  endtask

  function automatic logic [31:0] mix(input int i);
    return (32'h9E3779B9 * (i + 1)) ^ (32'h7F4A7C15 >> (i % 7));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !memReqValid && !doneValid, "R1 reset",
          {61'd0, busy, memReqValid, doneValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReqValid && !doneValid, "R1 after reset",
          {61'd0, busy, memReqValid, doneValid}, 64'd0);
    for (int cls = 0; cls < 7; cls++) begin
      for (int v = 0; v < 6; v++) begin
        logic [31:0] va, base, d1, d2;
        int n;
        n = cls * 6 + v;
        va = mix(n + 100); base = mix(n + 200); d1 = mix(n + 300); d2 = mix(n + 400);
        if (v == 0) va = 32'h0000_0000;
        if (v == 1) va = 32'hFFFF_FFFF;
        case (cls)
          0: d1[1:0] = 2'b00;                                    // R4
          1: d1[1:0] = 2'b11;                                    // R4
          2: begin d1[1:0] = 2'b10; d1[18] = 1'b0; end           // R5
          3: begin d1[1:0] = 2'b10; d1[18] = 1'b1; end           // R6
          4: begin d1[1:0] = 2'b01; d2[1] = 1'b1; end            // R7 R8
          5: begin d1[1:0] = 2'b01; d2[1:0] = 2'b00; end         // R9
          default: begin d1[1:0] = 2'b01; d2[1:0] = 2'b01; end   // R9
        endcase
        doWalk(va, base, d1, d2, v % 3, (v % 2) == 1);
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule